// File: doc/BRIEF.md
# Iterative Kasumi Block Encryptor

This block encrypts one 64-bit block with the Kasumi cipher under a 128-bit key. It computes one Feistel round per enabled clock, so a block needs eight enabled cycles. The first round is computed directly from the input pins on the launch edge. This lets a new block enter on the edge right after the previous result appears, which sustains one block every eight cycles, or 8 bits per clock. Only the encryption direction exists. The round subkeys are derived combinationally from the held key and the current round index, so no key schedule is stored.

The controller is a two-state machine. **IDLE** waits for a rising edge on `launch`. The transition **LAUNCH** (IDLE to RUN) captures the key, computes round 1 from `pt_in` and sets the round counter to 1. In **RUN**, the transition **STEP** (RUN to RUN) computes the next round while `launch` stays high. **FINISH** (RUN to IDLE) is taken on the edge that computes round 8, whatever the level of `launch`. It writes the result and raises `result_vld`. **ABORT** (RUN to IDLE) is taken when `launch` is sampled low on any earlier edge of the run. A low `clk_en` freezes every register, and the pins are ignored during that cycle.

Top module: `kasumi_iter_enc`

## Requirements
- R1: `ct_out` equals the Kasumi encryption of the launched plaintext under the launched key. The key is read with its most significant 16-bit word as key word 1, and the plaintext upper half is the left Feistel half. Key 2BD6459F82C5B300952C49104881FF48 encrypts EA024714AD5C4D84 to DF1F9B251C0BF45F.
- R2: A launch happens on an enabled edge where `launch` is 1 and was 0 at the previous enabled edge. `key_in` and `pt_in` are sampled on that edge only, and later changes to them do not alter the result.
- R3: `result_vld` is 0 after the launch edge and the six enabled edges that follow it. It becomes 1 after the seventh enabled edge that follows the launch edge, together with the new `ct_out`.
- R4: If `launch` is sampled low on any of the first six enabled edges after a launch, the run is abandoned. `result_vld` stays 0 and `ct_out` is unchanged. A low `launch` on the seventh edge, the final round, does not abandon the run.
- R5: Holding `launch` high after a run starts no further run.
- R6: While `clk_en` is 0, all state holds. A run paused this way completes with the correct result after the same count of enabled edges, and a `launch` pulse that occurs entirely while `clk_en` is 0 starts nothing.
- R7: A new launch is accepted on the enabled edge right after the one that completes the previous block. Each block may use a different key, giving one result every eight cycles.
- R8: Reset (synchronous, active high `rst`) sets `result_vld` to 0 and `ct_out` to 0, and returns the machine to IDLE.
- R9: `ct_out` changes only on the edge that completes a run. It holds across idle periods and aborted runs.
- R10: `result_vld` stays 1 until the next launch edge, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Synchronous enable; low freezes all state |
| launch | input | 1 | Rising level starts a run; low during a run abandons it |
| key_in | input | 128 | Cipher key, word 1 in bits 127:112 |
| pt_in | input | 64 | Plaintext block |
| ct_out | output | 64 | Ciphertext of the last completed run |
| result_vld | output | 1 | High from completion until the next launch |

## Verification
On every cycle, the assertions cover the state-machine transitions: the launch edge leads to RUN with the counter at 1 and the flag clear, the final round leads to a raised flag, an early low `launch` leads to IDLE, and a held `launch` starts nothing. They also check that a low enable or an idle cycle leaves `ct_out` and the flag unchanged. Only the bench scenarios can show that the ciphertext values are correct, against a published triple and an independent model. The same holds for pins being ignored after capture, paused runs finishing correctly, back-to-back blocks under changing keys, and aborts at every round position.

// File: rtl/kasumi_pkg.sv
`timescale 1ns/1ps
package kasumi_pkg;

    localparam int BLK_W      = 64;
    localparam int HALF_W     = BLK_W / 2;
    localparam int KEY_W      = 128;
    localparam int WORD_W     = 16;
    localparam int NUM_WORDS  = KEY_W / WORD_W;
    localparam int NUM_ROUNDS = 8;
    localparam int RND_W      = $clog2(NUM_ROUNDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef struct packed {
        word_t kl1, kl2;
        word_t ko1, ko2, ko3;
        word_t ki1, ki2, ki3;
    } subkey_t;

    function automatic word_t rotl(word_t v, int n);
        return (v << n) | (v >> (WORD_W - n));
    endfunction

    function automatic word_t mask_const(int idx);
        case (idx)
            0: return 16'h0123;
            1: return 16'h4567;
            2: return 16'h89AB;
            3: return 16'hCDEF;
            4: return 16'hFEDC;
            5: return 16'hBA98;
            6: return 16'h7654;
            default: return 16'h3210;
        endcase
    endfunction

    function automatic logic [6:0] sbox7(logic [6:0] x);
        logic a0, a1, a2, a3, a4, a5, a6;
        logic [6:0] y;
        {a6, a5, a4, a3, a2, a1, a0} = x;
        y[0] = (a1&a3) ^ a4 ^ (a0&a1&a4) ^ a5 ^ (a2&a5) ^ (a3&a4&a5) ^ a6 ^ (a0&a6)
             ^ (a1&a6) ^ (a3&a6) ^ (a2&a4&a6) ^ (a1&a5&a6) ^ (a4&a5&a6);
        y[1] = (a0&a1) ^ (a0&a4) ^ (a2&a4) ^ a5 ^ (a1&a2&a5) ^ (a0&a3&a5) ^ a6
             ^ (a0&a2&a6) ^ (a3&a6) ^ (a4&a5&a6) ^ 1'b1;
        y[2] = a0 ^ (a0&a3) ^ (a2&a3) ^ (a1&a2&a4) ^ (a0&a3&a4) ^ (a1&a5) ^ (a0&a2&a5)
             ^ (a0&a6) ^ (a0&a1&a6) ^ (a2&a6) ^ (a4&a6) ^ 1'b1;
        y[3] = a1 ^ (a0&a1&a2) ^ (a1&a4) ^ (a3&a4) ^ (a0&a5) ^ (a0&a1&a5) ^ (a2&a3&a5)
             ^ (a1&a4&a5) ^ (a2&a6) ^ (a1&a3&a6);
        y[4] = (a0&a2) ^ a3 ^ (a1&a3) ^ (a1&a4) ^ (a0&a1&a4) ^ (a2&a3&a4) ^ (a0&a5)
             ^ (a1&a3&a5) ^ (a0&a4&a5) ^ (a1&a6) ^ (a3&a6) ^ (a0&a3&a6) ^ (a5&a6) ^ 1'b1;
        y[5] = a2 ^ (a0&a2) ^ (a0&a3) ^ (a1&a2&a3) ^ (a0&a2&a4) ^ (a0&a5) ^ (a2&a5)
             ^ (a4&a5) ^ (a1&a6) ^ (a1&a2&a6) ^ (a0&a3&a6) ^ (a3&a4&a6) ^ (a2&a5&a6) ^ 1'b1;
        y[6] = (a1&a2) ^ (a0&a1&a3) ^ (a0&a4) ^ (a1&a5) ^ (a3&a5) ^ a6 ^ (a0&a1&a6)
             ^ (a2&a3&a6) ^ (a1&a4&a6) ^ (a0&a5&a6);
        return y;
    endfunction

    function automatic logic [8:0] sbox9(logic [8:0] x);
        logic a0, a1, a2, a3, a4, a5, a6, a7, a8;
        logic [8:0] y;
        {a8, a7, a6, a5, a4, a3, a2, a1, a0} = x;
        y[0] = (a0&a2) ^ a3 ^ (a2&a5) ^ (a5&a6) ^ (a0&a7) ^ (a1&a7) ^ (a2&a7) ^ (a4&a8)
             ^ (a5&a8) ^ (a7&a8) ^ 1'b1;
        y[1] = a1 ^ (a0&a1) ^ (a2&a3) ^ (a0&a4) ^ (a1&a4) ^ (a0&a5) ^ (a3&a5) ^ a6
             ^ (a1&a7) ^ (a2&a7) ^ (a5&a8) ^ 1'b1;
        y[2] = a1 ^ (a0&a3) ^ (a3&a4) ^ (a0&a5) ^ (a2&a6) ^ (a3&a6) ^ (a5&a6) ^ (a4&a7)
             ^ (a5&a7) ^ (a6&a7) ^ a8 ^ (a0&a8) ^ 1'b1;
        y[3] = a0 ^ (a1&a2) ^ (a0&a3) ^ (a2&a4) ^ a5 ^ (a0&a6) ^ (a1&a6) ^ (a4&a7)
             ^ (a0&a8) ^ (a1&a8) ^ (a7&a8);
        y[4] = (a0&a1) ^ (a1&a3) ^ a4 ^ (a0&a5) ^ (a3&a6) ^ (a0&a7) ^ (a6&a7) ^ (a1&a8)
             ^ (a2&a8) ^ (a3&a8);
        y[5] = a2 ^ (a1&a4) ^ (a4&a5) ^ (a0&a6) ^ (a1&a6) ^ (a3&a7) ^ (a4&a7) ^ (a6&a7)
             ^ (a5&a8) ^ (a6&a8) ^ (a7&a8) ^ 1'b1;
        y[6] = a0 ^ (a2&a3) ^ (a1&a5) ^ (a2&a5) ^ (a4&a5) ^ (a3&a6) ^ (a4&a6) ^ (a5&a6)
             ^ a7 ^ (a1&a8) ^ (a3&a8) ^ (a5&a8) ^ (a7&a8);
        y[7] = (a0&a1) ^ (a0&a2) ^ (a1&a2) ^ a3 ^ (a0&a3) ^ (a2&a3) ^ (a4&a5) ^ (a2&a6)
             ^ (a3&a6) ^ (a2&a7) ^ (a5&a7) ^ a8 ^ 1'b1;
        y[8] = (a0&a1) ^ a2 ^ (a1&a2) ^ (a3&a4) ^ (a1&a5) ^ (a2&a5) ^ (a1&a6) ^ (a4&a6)
             ^ a7 ^ (a2&a8) ^ (a3&a8);
        return y;
    endfunction

    // 16-bit nonlinear mixer: 9-bit upper part, 7-bit lower part
    function automatic word_t mix16(word_t v, word_t k);
        logic [8:0] hi0, hi1, lo2;
        logic [6:0] lo0, hi2, top;
        lo0 = v[6:0];
        hi1 = sbox9(v[15:7]) ^ {2'b00, lo0};
        hi0 = hi1 ^ k[8:0];
        hi2 = sbox7(lo0) ^ hi1[6:0] ^ k[15:9];
        lo2 = sbox9(hi0) ^ {2'b00, hi2};
        top = sbox7(hi2) ^ lo2[6:0];
        return {top, lo2};
    endfunction

    function automatic half_t fo_fn(half_t v, subkey_t sk);
        word_t l, r, t;
        l = v[31:16];
        r = v[15:0];
        t = mix16(l ^ sk.ko1, sk.ki1) ^ r; l = r; r = t;
        t = mix16(l ^ sk.ko2, sk.ki2) ^ r; l = r; r = t;
        t = mix16(l ^ sk.ko3, sk.ki3) ^ r; l = r; r = t;
        return {l, r};
    endfunction

    function automatic half_t fl_fn(half_t v, subkey_t sk);
        word_t l, r;
        l = v[31:16];
        r = v[15:0] ^ rotl(v[31:16] & sk.kl1, 1);
        l = l ^ rotl(r | sk.kl2, 1);
        return {l, r};
    endfunction

endpackage

// File: rtl/ksm_keysched.sv
`timescale 1ns/1ps
module ksm_keysched
    import kasumi_pkg::*;
(
    input  logic [KEY_W-1:0] key,
    input  logic [RND_W-1:0] ridx,
    output subkey_t          sk
);
    word_t kw [NUM_WORDS];
    word_t kp [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        assign kw[g] = key[KEY_W-1-g*WORD_W -: WORD_W];
        assign kp[g] = key[KEY_W-1-g*WORD_W -: WORD_W] ^ mask_const(g);
    end

    // word index offsets wrap naturally in RND_W bits
    function automatic logic [RND_W-1:0] wofs(logic [RND_W-1:0] base, int ofs);
        return base + RND_W'(ofs);
    endfunction

    always_comb begin
        sk.kl1 = rotl(kw[ridx], 1);
        sk.kl2 = kp[wofs(ridx, 2)];
        sk.ko1 = rotl(kw[wofs(ridx, 1)], 5);
        sk.ko2 = rotl(kw[wofs(ridx, 5)], 8);
        sk.ko3 = rotl(kw[wofs(ridx, 6)], 13);
        sk.ki1 = kp[wofs(ridx, 4)];
        sk.ki2 = kp[wofs(ridx, 3)];
        sk.ki3 = kp[wofs(ridx, 7)];
    end
endmodule

// File: rtl/ksm_round.sv
`timescale 1ns/1ps
module ksm_round
    import kasumi_pkg::*;
(
    input  logic [BLK_W-1:0] blk,
    input  subkey_t          sk,
    input  logic             odd_rnd,
    output logic [BLK_W-1:0] blk_nxt
);
    half_t left, right, fval;

    assign left  = blk[BLK_W-1:HALF_W];
    assign right = blk[HALF_W-1:0];

    always_comb begin
        if (odd_rnd) fval = fo_fn(fl_fn(left, sk), sk);
        else         fval = fl_fn(fo_fn(left, sk), sk);
    end

    assign blk_nxt = {right ^ fval, left};
endmodule

// File: rtl/ksm_ctrl.sv
`timescale 1ns/1ps
module ksm_ctrl
    import kasumi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             launch,
    output logic             cap,
    output logic             adv,
    output logic             fin,
    output logic [RND_W-1:0] rsel,
    output logic             result_vld
);
    typedef enum logic {ST_IDLE, ST_RUN} state_t;
    localparam logic [RND_W-1:0] LAST = RND_W'(NUM_ROUNDS - 1);

    state_t           state, state_nxt;
    logic [RND_W-1:0] rnd, rnd_nxt;
    logic             launch_q;
    logic             rising;

    assign rising = launch && !launch_q;

    always_comb begin
        state_nxt = state;
        rnd_nxt   = rnd;
        unique case (state)
            ST_IDLE: begin
                if (rising) begin              // LAUNCH
                    state_nxt = ST_RUN;
                    rnd_nxt   = RND_W'(1);
                end
            end
            ST_RUN: begin
                if (rnd == LAST) begin         // FINISH
                    state_nxt = ST_IDLE;
                    rnd_nxt   = '0;
                end else if (!launch) begin    // ABORT
                    state_nxt = ST_IDLE;
                    rnd_nxt   = '0;
                end else begin                 // STEP
                    rnd_nxt   = rnd + RND_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            rnd      <= '0;
            launch_q <= 1'b0;
        end else if (clk_en) begin
            state    <= state_nxt;
            rnd      <= rnd_nxt;
            launch_q <= launch;
        end
    end

    always_comb begin
        cap  = clk_en && (state == ST_IDLE) && rising;
        adv  = clk_en && (state == ST_RUN) && (launch || rnd == LAST);
        fin  = clk_en && (state == ST_RUN) && (rnd == LAST);
        rsel = cap ? '0 : rnd;
    end

    always_ff @(posedge clk) begin
        if (rst)      result_vld <= 1'b0;
        else if (cap) result_vld <= 1'b0;
        else if (fin) result_vld <= 1'b1;
    end

    AST_LAUNCH_ENTERS_RUN: assert property (@(posedge clk) disable iff (rst)
        (clk_en && state == ST_IDLE && launch && !launch_q)
        |=> (state == ST_RUN && rnd == RND_W'(1) && !result_vld)); // R2
    AST_FINAL_ROUND_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (clk_en && state == ST_RUN && rnd == LAST)
        |=> (result_vld && state == ST_IDLE)); // R3
    AST_EARLY_DROP_ABORTS: assert property (@(posedge clk) disable iff (rst)
        (clk_en && state == ST_RUN && rnd != LAST && !launch)
        |=> (state == ST_IDLE && !result_vld)); // R4
    AST_HELD_NO_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
        (clk_en && state == ST_IDLE && launch && launch_q)
        |=> (state == ST_IDLE)); // R5
    AST_DISABLED_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!clk_en) |=> ($stable(state) && $stable(rnd) && $stable(launch_q))); // R6
    AST_FLAG_PERSISTS: assert property (@(posedge clk) disable iff (rst)
        (result_vld && !(clk_en && state == ST_IDLE && launch && !launch_q))
        |=> result_vld); // R10
endmodule

// File: rtl/kasumi_iter_enc.sv
`timescale 1ns/1ps
module kasumi_iter_enc
    import kasumi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             launch,
    input  logic [KEY_W-1:0] key_in,
    input  logic [BLK_W-1:0] pt_in,
    output logic [BLK_W-1:0] ct_out,
    output logic             result_vld
);
    logic             cap, adv, fin;
    logic [RND_W-1:0] rsel;
    logic [BLK_W-1:0] blk_q, blk_src, blk_nxt;
    logic [KEY_W-1:0] key_q, key_src;
    subkey_t          sk;

    ksm_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .launch     (launch),
        .cap        (cap),
        .adv        (adv),
        .fin        (fin),
        .rsel       (rsel),
        .result_vld (result_vld)
    );

    // round 1 is taken straight from the pins on the launch edge
    assign blk_src = cap ? pt_in  : blk_q;
    assign key_src = cap ? key_in : key_q;

    ksm_keysched u_ks (
        .key  (key_src),
        .ridx (rsel),
        .sk   (sk)
    );

    ksm_round u_rnd (
        .blk     (blk_src),
        .sk      (sk),
        .odd_rnd (!rsel[0]),
        .blk_nxt (blk_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q  <= '0;
            key_q  <= '0;
            ct_out <= '0;
        end else begin
            if (cap) begin
                blk_q <= blk_nxt;
                key_q <= key_in;
            end else if (adv) begin
                blk_q <= blk_nxt;
            end
            if (fin) ct_out <= blk_nxt;
        end
    end

    AST_OUT_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!clk_en) |=> ($stable(ct_out) && $stable(result_vld))); // R6
    AST_OUT_ONLY_ON_FINISH: assert property (@(posedge clk) disable iff (rst)
        (!fin) |=> $stable(ct_out)); // R9
endmodule

// File: tb/kasumi_iter_enc_bench.sv
`timescale 1ns/1ps
module kasumi_iter_enc_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clk_en = 1'b1;
    logic         launch = 1'b0;
    logic [127:0] key_in = '0;
    logic [63:0]  pt_in = '0;
    logic [63:0]  ct_out;
    logic         result_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    kasumi_iter_enc u_kasumi_iter_enc (
        .clk(clk), .rst(rst), .clk_en(clk_en), .launch(launch),
        .key_in(key_in), .pt_in(pt_in), .ct_out(ct_out), .result_vld(result_vld)
    );

    // ---------------- reference model ----------------
    function automatic logic [6:0] m_s7(logic [6:0] x);
        logic [6:0] y;
        y[0] = x[1]&x[3] ^ x[4] ^ x[0]&x[1]&x[4] ^ x[5] ^ x[2]&x[5] ^ x[3]&x[4]&x[5] ^ x[6]
             ^ x[0]&x[6] ^ x[1]&x[6] ^ x[3]&x[6] ^ x[2]&x[4]&x[6] ^ x[1]&x[5]&x[6] ^ x[4]&x[5]&x[6];
        y[1] = x[0]&x[1] ^ x[0]&x[4] ^ x[2]&x[4] ^ x[5] ^ x[1]&x[2]&x[5] ^ x[0]&x[3]&x[5] ^ x[6]
             ^ x[0]&x[2]&x[6] ^ x[3]&x[6] ^ x[4]&x[5]&x[6] ^ 1'b1;
        y[2] = x[0] ^ x[0]&x[3] ^ x[2]&x[3] ^ x[1]&x[2]&x[4] ^ x[0]&x[3]&x[4] ^ x[1]&x[5]
             ^ x[0]&x[2]&x[5] ^ x[0]&x[6] ^ x[0]&x[1]&x[6] ^ x[2]&x[6] ^ x[4]&x[6] ^ 1'b1;
        y[3] = x[1] ^ x[0]&x[1]&x[2] ^ x[1]&x[4] ^ x[3]&x[4] ^ x[0]&x[5] ^ x[0]&x[1]&x[5]
             ^ x[2]&x[3]&x[5] ^ x[1]&x[4]&x[5] ^ x[2]&x[6] ^ x[1]&x[3]&x[6];
        y[4] = x[0]&x[2] ^ x[3] ^ x[1]&x[3] ^ x[1]&x[4] ^ x[0]&x[1]&x[4] ^ x[2]&x[3]&x[4]
             ^ x[0]&x[5] ^ x[1]&x[3]&x[5] ^ x[0]&x[4]&x[5] ^ x[1]&x[6] ^ x[3]&x[6]
             ^ x[0]&x[3]&x[6] ^ x[5]&x[6] ^ 1'b1;
        y[5] = x[2] ^ x[0]&x[2] ^ x[0]&x[3] ^ x[1]&x[2]&x[3] ^ x[0]&x[2]&x[4] ^ x[0]&x[5]
             ^ x[2]&x[5] ^ x[4]&x[5] ^ x[1]&x[6] ^ x[1]&x[2]&x[6] ^ x[0]&x[3]&x[6]
             ^ x[3]&x[4]&x[6] ^ x[2]&x[5]&x[6] ^ 1'b1;
        y[6] = x[1]&x[2] ^ x[0]&x[1]&x[3] ^ x[0]&x[4] ^ x[1]&x[5] ^ x[3]&x[5] ^ x[6]
             ^ x[0]&x[1]&x[6] ^ x[2]&x[3]&x[6] ^ x[1]&x[4]&x[6] ^ x[0]&x[5]&x[6];
        return y;
    endfunction

    function automatic logic [8:0] m_s9(logic [8:0] x);
        logic [8:0] y;
        y[0] = x[0]&x[2] ^ x[3] ^ x[2]&x[5] ^ x[5]&x[6] ^ x[0]&x[7] ^ x[1]&x[7] ^ x[2]&x[7]
             ^ x[4]&x[8] ^ x[5]&x[8] ^ x[7]&x[8] ^ 1'b1;
        y[1] = x[1] ^ x[0]&x[1] ^ x[2]&x[3] ^ x[0]&x[4] ^ x[1]&x[4] ^ x[0]&x[5] ^ x[3]&x[5]
             ^ x[6] ^ x[1]&x[7] ^ x[2]&x[7] ^ x[5]&x[8] ^ 1'b1;
        y[2] = x[1] ^ x[0]&x[3] ^ x[3]&x[4] ^ x[0]&x[5] ^ x[2]&x[6] ^ x[3]&x[6] ^ x[5]&x[6]
             ^ x[4]&x[7] ^ x[5]&x[7] ^ x[6]&x[7] ^ x[8] ^ x[0]&x[8] ^ 1'b1;
        y[3] = x[0] ^ x[1]&x[2] ^ x[0]&x[3] ^ x[2]&x[4] ^ x[5] ^ x[0]&x[6] ^ x[1]&x[6]
             ^ x[4]&x[7] ^ x[0]&x[8] ^ x[1]&x[8] ^ x[7]&x[8];
        y[4] = x[0]&x[1] ^ x[1]&x[3] ^ x[4] ^ x[0]&x[5] ^ x[3]&x[6] ^ x[0]&x[7] ^ x[6]&x[7]
             ^ x[1]&x[8] ^ x[2]&x[8] ^ x[3]&x[8];
        y[5] = x[2] ^ x[1]&x[4] ^ x[4]&x[5] ^ x[0]&x[6] ^ x[1]&x[6] ^ x[3]&x[7] ^ x[4]&x[7]
             ^ x[6]&x[7] ^ x[5]&x[8] ^ x[6]&x[8] ^ x[7]&x[8] ^ 1'b1;
        y[6] = x[0] ^ x[2]&x[3] ^ x[1]&x[5] ^ x[2]&x[5] ^ x[4]&x[5] ^ x[3]&x[6] ^ x[4]&x[6]
             ^ x[5]&x[6] ^ x[7] ^ x[1]&x[8] ^ x[3]&x[8] ^ x[5]&x[8] ^ x[7]&x[8];
        y[7] = x[0]&x[1] ^ x[0]&x[2] ^ x[1]&x[2] ^ x[3] ^ x[0]&x[3] ^ x[2]&x[3] ^ x[4]&x[5]
             ^ x[2]&x[6] ^ x[3]&x[6] ^ x[2]&x[7] ^ x[5]&x[7] ^ x[8] ^ 1'b1;
        y[8] = x[0]&x[1] ^ x[2] ^ x[1]&x[2] ^ x[3]&x[4] ^ x[1]&x[5] ^ x[2]&x[5] ^ x[1]&x[6]
             ^ x[4]&x[6] ^ x[7] ^ x[2]&x[8] ^ x[3]&x[8];
        return y;
    endfunction

    function automatic logic [15:0] m_rol(logic [15:0] v, int n);
        return (v << n) | (v >> (16 - n));
    endfunction

    function automatic logic [15:0] m_fi(logic [15:0] in, logic [15:0] k);
        logic [8:0] l, r9;
        logic [6:0] r, l7;
        l = in[15:7]; r = in[6:0];
        r9 = m_s9(l) ^ {2'b0, r};  l7 = r;
        l  = r9 ^ k[8:0];          r  = m_s7(l7) ^ r9[6:0] ^ k[15:9];
        r9 = m_s9(l) ^ {2'b0, r};
        l7 = m_s7(r) ^ r9[6:0];
        return {l7, r9};
    endfunction

    function automatic logic [15:0] m_cst(int i);
        logic [15:0] t [8];
        t = '{16'h0123, 16'h4567, 16'h89AB, 16'hCDEF, 16'hFEDC, 16'hBA98, 16'h7654, 16'h3210};
        return t[i];
    endfunction

    function automatic logic [63:0] m_kasumi(logic [127:0] k, logic [63:0] p);
        logic [15:0] kw [8];
        logic [15:0] kp [8];
        logic [15:0] ko [3];
        logic [15:0] ki [3];
        logic [15:0] kl1, kl2, a, b, t;
        logic [31:0] l, r, x, f;
        for (int n = 0; n < 8; n++) begin
            kw[n] = k[127-16*n -: 16];
            kp[n] = kw[n] ^ m_cst(n);
        end
        l = p[63:32]; r = p[31:0];
        for (int i = 0; i < 8; i++) begin
            kl1 = m_rol(kw[i], 1);          kl2 = kp[(i+2)%8];
            ko[0] = m_rol(kw[(i+1)%8], 5);  ko[1] = m_rol(kw[(i+5)%8], 8);
            ko[2] = m_rol(kw[(i+6)%8], 13);
            ki[0] = kp[(i+4)%8]; ki[1] = kp[(i+3)%8]; ki[2] = kp[(i+7)%8];
            x = l;
            for (int pass = 0; pass < 2; pass++) begin
                if ((pass == 0) == (i % 2 == 0)) begin
                    b = x[15:0] ^ m_rol(x[31:16] & kl1, 1);
                    a = x[31:16] ^ m_rol(b | kl2, 1);
                    x = {a, b};
                end else begin
                    a = x[31:16]; b = x[15:0];
                    for (int j = 0; j < 3; j++) begin
                        t = m_fi(a ^ ko[j], ki[j]) ^ b; a = b; b = t;
                    end
                    x = {a, b};
                end
            end
            f = x;
            x = r ^ f; r = l; l = x;
        end
        return {l, r};
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [127:0] rkey();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction
    function automatic logic [63:0] rblk();
        return {$urandom, $urandom};
    endfunction

    // full run: launch, scramble pins after capture, check latency and result
    task automatic run_block(input logic [127:0] k, input logic [63:0] p);
        logic [63:0] exp;
        exp = m_kasumi(k, p);
        launch = 1'b0; clk_en = 1'b1;
        @(negedge clk);
        launch = 1'b1; key_in = k; pt_in = p;
        @(negedge clk);
        key_in = rkey(); pt_in = rblk();                 // R2: ignored after capture
        repeat (6) @(negedge clk);
        check({63'b0, result_vld}, 64'd0, "R3 flag low before final round");
        @(negedge clk);
        check({63'b0, result_vld}, 64'd1, "R3 flag after seventh edge");
        check(ct_out, exp, "R1 R2 ciphertext");
    endtask

    logic [63:0] prev;
    logic [127:0] kq [5];
    logic [63:0]  pq [5];

    initial begin
        void'($urandom(32'h5A17_C0DE));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check({63'b0, result_vld}, 64'd0, "R8 flag after reset");
        check(ct_out, 64'd0, "R8 output after reset");

        // published triple
        check(m_kasumi(128'h2BD6459F82C5B300952C49104881FF48, 64'hEA024714AD5C4D84),
              64'hDF1F9B251C0BF45F, "R1 model vs published");
        run_block(128'h2BD6459F82C5B300952C49104881FF48, 64'hEA024714AD5C4D84);
        check(ct_out, 64'hDF1F9B251C0BF45F, "R1 published ciphertext");

        // directed corners
        run_block('0, '0);
        run_block('1, '1);

        // held launch: no new run, flag and output persist
        prev = ct_out;
        repeat (12) @(negedge clk);
        check({63'b0, result_vld}, 64'd1, "R5 R10 flag held with launch high");
        check(ct_out, prev, "R5 output held with launch high");

        // next launch clears the flag
        launch = 1'b0; @(negedge clk);
        launch = 1'b1; key_in = rkey(); pt_in = rblk();
        prev = m_kasumi(key_in, pt_in);
        @(negedge clk);
        check({63'b0, result_vld}, 64'd0, "R10 flag cleared by launch");
        repeat (7) @(negedge clk);
        check(ct_out, prev, "R1 result after relaunch");

        // aborts at each early round
        for (int k = 1; k <= 6; k++) begin
            prev = ct_out;
            launch = 1'b0; @(negedge clk);
            launch = 1'b1; key_in = rkey(); pt_in = rblk();
            repeat (k) @(negedge clk);
            launch = 1'b0;
            repeat (12) @(negedge clk);
            check({63'b0, result_vld}, 64'd0, "R4 no flag after abort");
            check(ct_out, prev, "R4 R9 output kept after abort");
        end

        // drop on the final-round edge still completes
        launch = 1'b1; key_in = rkey(); pt_in = rblk();
        prev = m_kasumi(key_in, pt_in);
        repeat (7) @(negedge clk);
        launch = 1'b0;
        @(negedge clk);
        check({63'b0, result_vld}, 64'd1, "R4 final-edge drop completes");
        check(ct_out, prev, "R4 final-edge drop result");

        // back-to-back blocks with changing keys
        for (int b = 0; b < 5; b++) begin kq[b] = rkey(); pq[b] = rblk(); end
        @(negedge clk);
        for (int b = 0; b < 5; b++) begin
            launch = 1'b1; key_in = kq[b]; pt_in = pq[b];
            repeat (7) @(negedge clk);
            launch = 1'b0;
            @(negedge clk);
            check({63'b0, result_vld}, 64'd1, "R7 flag every eight cycles");
            check(ct_out, m_kasumi(kq[b], pq[b]), "R7 back-to-back result");
        end

        // enable gaps during runs
        for (int n = 0; n < 6; n++) begin
            int cnt;
            kq[0] = rkey(); pq[0] = rblk();
            launch = 1'b0; clk_en = 1'b1; @(negedge clk);
            launch = 1'b1; key_in = kq[0]; pt_in = pq[0];
            cnt = 1;
            forever begin
                @(negedge clk);
                if (cnt == 8) break;
                check({63'b0, result_vld}, 64'd0, "R6 flag low while paused run");
                clk_en = ($urandom % 3) != 0;
                if (clk_en) cnt++;
            end
            clk_en = 1'b1;
            check({63'b0, result_vld}, 64'd1, "R6 flag after gated run");
            check(ct_out, m_kasumi(kq[0], pq[0]), "R6 gated run result");
        end

        // launch pulse entirely while disabled is ignored
        prev = ct_out;
        launch = 1'b0; @(negedge clk);
        clk_en = 1'b0; launch = 1'b1; pt_in = rblk(); key_in = rkey();
        repeat (2) @(negedge clk);
        launch = 1'b0; @(negedge clk);
        clk_en = 1'b1;
        repeat (10) @(negedge clk);
        check({63'b0, result_vld}, 64'd1, "R6 disabled pulse leaves flag");
        check(ct_out, prev, "R6 R9 disabled pulse leaves output");

        // random traffic
        for (int n = 0; n < 24; n++) run_block(rkey(), rblk());

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL R3 watchdog: actual no end expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule